// File: doc/BRIEF.md
# Vertical Sync Flywheel and Field Flag Generator

This block produces the frame-timing flags on a video decoder's output port: a vertical sync pulse, a field identity flag and an active-video flag. Its inputs are a one-cycle line strobe, a one-cycle strobe for a detected vertical sync, an active-region indicator, a burst-mode select and a synchronous soft reset, all on the pixel clock.

While the incoming video carries vertical sync, each detected sync starts a vertical pulse and flips the field flag. When sync goes missing, a line counter keeps running. Once the set number of lines has passed with no sync (337 by default), it supplies the event itself, so the pulse and the field toggle go on at the flywheel rate. A detected sync restarts the counter, so the block locks back to the input at once.

After a hardware or soft reset, all three outputs are in high impedance, shown by their enables being low. They are driven again from the first line strobe after reset.

Top module: `vsync_flywheel`

## Requirements
- R1: While `rst_ni` is low, and one cycle after `soft_rst_i` is sampled high, all three output enables are low, `vsync_o` is 0 and `field_o` is 1.
- R2: The enables go high one cycle after the first `line_stb_i` following reset. They then stay high until the next reset.
- R3: A sampled `vsync_det_i` gives, one cycle later, `vsync_o` = 1 and an inverted `field_o`. It also restarts the line count from zero.
- R4: `vsync_o` stays high from an event until `PULSE_LINES` further line strobes have been sampled, and it falls one cycle after the last of them. A new event during the pulse reloads the full width.
- R5: With no detected sync, the `TIMEOUT_LINES`-th line strobe after the last event is a flywheel event. One cycle later `field_o` is inverted and `vsync_o` is 1. The count then restarts.
- R6: Field encoding: `field_o` = 0 marks an odd field and `field_o` = 1 an even field. The field changes only on an event or a reset.
- R7: One cycle after any sample, `active_o` equals `active_i | burst_i` from that sample. In burst mode it is therefore always 1.
- R8: When `vsync_det_i` and `line_stb_i` arrive in the same cycle, the detection wins. That line strobe is not counted toward the timeout.
- R9: `soft_rst_i` overrides a detection or line strobe in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| soft_rst_i | input | 1 | Synchronous soft reset |
| line_stb_i | input | 1 | One-cycle strobe per video line |
| vsync_det_i | input | 1 | One-cycle strobe on a detected input vertical sync |
| active_i | input | 1 | Active portion of the line is on the output port |
| burst_i | input | 1 | Burst output mode select |
| vsync_o | output | 1 | Vertical sync pulse |
| vsync_oe_o | output | 1 | Output enable for vsync_o |
| field_o | output | 1 | Field flag, 0 odd, 1 even |
| field_oe_o | output | 1 | Output enable for field_o |
| active_o | output | 1 | Active video flag |
| active_oe_o | output | 1 | Output enable for active_o |

## Verification
Every result is registered, so each output is due exactly one clock after the edge that samples its cause. This covers the field flip, the pulse start and end, the enable release and the active flag. The bench applies inputs at the falling edge and keeps a cycle model made of functions. It compares all six outputs one time unit after each rising edge. Directed runs count line strobes up to the timeout: they check that the field holds after 336 strobes and flips after the 337th, including the case where a detection and a strobe coincide.

// File: rtl/vfw_pkg.sv
package vfw_pkg;
  localparam logic FIELD_ODD  = 1'b0;
  localparam logic FIELD_EVEN = 1'b1;

  typedef struct packed {
    logic vsync;
    logic field;
    logic active;
  } vfw_flags_t;
endpackage

// File: rtl/vfw_line_timer.sv
module vfw_line_timer #(
  parameter int unsigned TIMEOUT_LINES = 337
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic srst_i,
  input  logic line_stb_i,
  input  logic vsync_det_i,
  output logic evt_o
);
  localparam int unsigned CNT_W = (TIMEOUT_LINES > 2) ? $clog2(TIMEOUT_LINES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT_LINES - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             timeout;

  assign timeout = line_stb_i && !vsync_det_i && (cnt_q == LAST);
  assign evt_o   = !srst_i && (vsync_det_i || timeout);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (srst_i || vsync_det_i)  cnt_q <= '0;
    else if (line_stb_i)             cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST) else $error("count past timeout"); // R5
  AST_DET_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vsync_det_i |=> cnt_q == '0) else $error("detect did not restart count"); // R8
endmodule

// File: rtl/vfw_pulse_gen.sv
module vfw_pulse_gen #(
  parameter int unsigned PULSE_LINES = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic srst_i,
  input  logic line_stb_i,
  input  logic evt_i,
  output logic vsync_o
);
  localparam int unsigned PW = $clog2(PULSE_LINES + 1);

  logic [PW-1:0] left_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       left_q <= '0;
    else if (srst_i)                   left_q <= '0;
    else if (evt_i)                    left_q <= PW'(PULSE_LINES);
    else if (line_stb_i && left_q != 0) left_q <= left_q - 1'b1;
  end

  assign vsync_o = (left_q != '0);

  AST_PULSE_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i && !srst_i) |=> vsync_o) else $error("no pulse on event"); // R4
  AST_PULSE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vsync_o && !line_stb_i && !srst_i) |=> vsync_o) else $error("pulse ended off strobe"); // R4
endmodule

// File: rtl/vfw_field_ctl.sv
module vfw_field_ctl
  import vfw_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic srst_i,
  input  logic line_stb_i,
  input  logic evt_i,
  output logic field_o,
  output logic oe_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      field_o <= FIELD_EVEN;
      oe_o    <= 1'b0;
    end else if (srst_i) begin
      field_o <= FIELD_EVEN;
      oe_o    <= 1'b0;
    end else begin
      if (evt_i)      field_o <= ~field_o;
      if (line_stb_i) oe_o    <= 1'b1;
    end
  end

  AST_FIELD_TOGGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i && !srst_i) |=> field_o != $past(field_o)) else $error("field did not flip"); // R3
  AST_FIELD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!evt_i && !srst_i) |=> $stable(field_o)) else $error("field moved without event"); // R6
  AST_OE_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oe_o && !srst_i) |=> oe_o) else $error("enable dropped"); // R2
  AST_SRST_HIZ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst_i |=> !oe_o) else $error("enable after soft reset"); // R1
endmodule

// File: rtl/vfw_active_gen.sv
module vfw_active_gen (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic srst_i,
  input  logic active_i,
  input  logic burst_i,
  output logic active_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     active_o <= 1'b0;
    else if (srst_i) active_o <= 1'b0;
    else             active_o <= active_i | burst_i;
  end

  AST_BURST_ACTIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (burst_i && !srst_i) |=> active_o) else $error("active low in burst"); // R7
endmodule

// File: rtl/vsync_flywheel.sv
module vsync_flywheel
  import vfw_pkg::*;
#(
  parameter int unsigned TIMEOUT_LINES = 337,
  parameter int unsigned PULSE_LINES   = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic soft_rst_i,
  input  logic line_stb_i,
  input  logic vsync_det_i,
  input  logic active_i,
  input  logic burst_i,
  output logic vsync_o,
  output logic vsync_oe_o,
  output logic field_o,
  output logic field_oe_o,
  output logic active_o,
  output logic active_oe_o
);
  localparam int unsigned N_OUT = 3;

  logic       evt;
  logic       oe;
  vfw_flags_t flags;
  logic [N_OUT-1:0] oe_vec;

  vfw_line_timer #(.TIMEOUT_LINES(TIMEOUT_LINES)) u_timer (
    .clk_i, .rst_ni, .srst_i(soft_rst_i), .line_stb_i, .vsync_det_i, .evt_o(evt)
  );

  vfw_pulse_gen #(.PULSE_LINES(PULSE_LINES)) u_pulse (
    .clk_i, .rst_ni, .srst_i(soft_rst_i), .line_stb_i, .evt_i(evt), .vsync_o(flags.vsync)
  );

  vfw_field_ctl u_field (
    .clk_i, .rst_ni, .srst_i(soft_rst_i), .line_stb_i, .evt_i(evt),
    .field_o(flags.field), .oe_o(oe)
  );

  vfw_active_gen u_active (
    .clk_i, .rst_ni, .srst_i(soft_rst_i), .active_i, .burst_i, .active_o(flags.active)
  );

  for (genvar g = 0; g < N_OUT; g++) begin : g_oe
    assign oe_vec[g] = oe;
  end

  assign vsync_o     = flags.vsync;
  assign field_o     = flags.field;
  assign active_o    = flags.active;
  assign vsync_oe_o  = oe_vec[0];
  assign field_oe_o  = oe_vec[1];
  assign active_oe_o = oe_vec[2];

  AST_OE_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(vsync_oe_o) |-> $past(line_stb_i)) else $error("enable without strobe"); // R2
endmodule

// File: tb/vsync_flywheel_test.sv
module vsync_flywheel_test;
  localparam int CLK_PERIOD = 10;
  localparam int TO = 337;
  localparam int PW = 3;

  typedef struct {
    int  cnt;
    int  left;
    bit  field;
    bit  oe;
    bit  act;
  } model_t;

  logic clk = 0, rst_ni = 0, soft_rst_i = 0, line_stb_i = 0, vsync_det_i = 0;
  logic active_i = 0, burst_i = 0;
  logic vsync_o, vsync_oe_o, field_o, field_oe_o, active_o, active_oe_o;

  int checks = 0, errors = 0;
  bit done = 0;
  model_t m;

  vsync_flywheel #(.TIMEOUT_LINES(TO), .PULSE_LINES(PW)) uut (
    .clk_i(clk), .rst_ni, .soft_rst_i, .line_stb_i, .vsync_det_i, .active_i, .burst_i,
    .vsync_o, .vsync_oe_o, .field_o, .field_oe_o, .active_o, .active_oe_o
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic model_t reset_model();
    model_t r;
    r.cnt = 0; r.left = 0; r.field = 1; r.oe = 0; r.act = 0;
    return r;
  endfunction

  function automatic model_t next_model(model_t s, bit ls, bit det, bit a, bit b, bit sr);
    model_t r = s;
    bit evt;
    if (sr) return reset_model();
    evt = det || (ls && s.cnt == TO - 1);
    if (det) r.cnt = 0;
    else if (ls) r.cnt = (s.cnt == TO - 1) ? 0 : s.cnt + 1;
    if (evt) begin
      r.field = ~s.field;
      r.left = PW;
    end else if (ls && s.left > 0) r.left = s.left - 1;
    if (ls) r.oe = 1;
    r.act = a | b;
    return r;
  endfunction

  task automatic chk(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cmp_all();
    chk("R2 vsync_oe", vsync_oe_o, m.oe);
    chk("R2 field_oe", field_oe_o, m.oe);
    chk("R2 active_oe", active_oe_o, m.oe);
    chk("R4 vsync", vsync_o, m.left > 0);
    chk("R3 field", field_o, m.field);
    chk("R7 active", active_o, m.act);
  endtask

  task automatic step(bit ls, bit det, bit a, bit b, bit sr);
    @(negedge clk);
    line_stb_i = ls; vsync_det_i = det; active_i = a; burst_i = b; soft_rst_i = sr;
    m = next_model(m, ls, det, a, b, sr);
    @(posedge clk);
    #1;
    cmp_all();
  endtask

  // one line: strobe then a few idle cycles with random active/burst
  task automatic run_line(bit det, bit burst);
    step(1, det, 1'($urandom), burst, 0);
    for (int k = 0; k < 2 + int'($urandom % 3); k++)
      step(0, 0, 1'($urandom), burst, 0);
  endtask

  initial begin
    bit f0;
    void'($urandom(32'd4711));
    m = reset_model();
    #(CLK_PERIOD * 3);
    // R1: reset state while rst_ni low
    chk("R1 oe in reset", vsync_oe_o, 0);
    chk("R1 vsync in reset", vsync_o, 0);
    chk("R1 field in reset", field_o, 1);
    @(negedge clk); rst_ni = 1;
    // R2: no enable before first strobe
    for (int i = 0; i < 4; i++) step(0, 0, 1, 0, 0);
    chk("R2 oe before strobe", field_oe_o, 0);
    step(1, 0, 0, 0, 0);
    chk("R2 oe after first strobe", active_oe_o, 1);

    // R3/R6: first detection flips even to odd
    step(0, 1, 0, 0, 0);
    chk("R3 vsync after detect", vsync_o, 1);
    chk("R6 odd field is 0", field_o, 0);

    // locked input with random line lengths and burst
    for (int f = 0; f < 6; f++) begin
      bit b = 1'($urandom);
      run_line(1, b);
      for (int l = 0; l < 40 + int'($urandom % 60); l++) run_line(0, b);
      if (b) chk("R7 burst keeps active", active_o, 1);
    end

    // R5: loss of sync, toggle on 337th strobe
    step(0, 1, 0, 0, 0);
    f0 = m.field;
    for (int l = 0; l < TO - 1; l++) run_line(0, 0);
    chk("R5 no toggle at 336", field_o, f0);
    step(1, 0, 0, 0, 0);
    chk("R5 toggle at 337", field_o, ~f0);
    chk("R5 flywheel vsync", vsync_o, 1);
    for (int l = 0; l < TO + 10; l++) run_line(0, 1'($urandom));

    // R8: detect and strobe together, strobe not counted
    step(1, 1, 0, 0, 0);
    f0 = m.field;
    for (int l = 0; l < TO - 1; l++) run_line(0, 0);
    chk("R8 no toggle after 336", field_o, f0);
    step(1, 0, 0, 0, 0);
    chk("R8 toggle at 337", field_o, ~f0);

    // R4: detect during pulse reloads width
    step(1, 0, 0, 0, 0);
    step(0, 1, 0, 0, 0);
    for (int l = 0; l < PW - 1; l++) step(1, 0, 0, 0, 0);
    chk("R4 pulse held after reload", vsync_o, 1);
    step(1, 0, 0, 0, 0);
    chk("R4 pulse ends", vsync_o, 0);

    // reacquire sync after loss
    for (int l = 0; l < 20; l++) run_line(0, 0);
    for (int f = 0; f < 3; f++) begin
      run_line(1, 0);
      for (int l = 0; l < 250; l++) run_line(0, 0);
    end

    // R9/R1: soft reset beats detect and strobe
    step(1, 1, 1, 1, 1);
    chk("R9 oe after soft reset", vsync_oe_o, 0);
    chk("R9 vsync after soft reset", vsync_o, 0);
    chk("R9 field after soft reset", field_o, 1);
    chk("R1 active after soft reset", active_o, 0);
    step(0, 0, 0, 0, 0);
    chk("R1 oe stays low", field_oe_o, 0);
    for (int l = 0; l < 30; l++) run_line(($urandom % 10) == 0, 1'($urandom));

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule